// File: doc/BRIEF.md
# PCI-X Outbound Configuration Address and Error Handler

This block sits beside the engine that issues configuration transactions from an internal bus master onto a PCI-X segment. It builds the 32-bit configuration address from the bus, device, function and register fields. The layout depends on the active bus mode. In Mode 2, the upper register bits extend the reachable space to 4 KB per function, and only the low device numbers can be targeted.

When a transaction ends, the block turns the bus outcome into the completion that goes back to the internal master. A failed read returns an aborted completion. Writes complete normally, and any error on a write arrives later as a split completion error message, which the block decodes.

Two error conditions are recorded, but only while parity checking is enabled:
- a split completion that reports write uncorrectable data;
- a data error on a read.

Each condition is kept in two identical sticky status registers: one for the translation unit and one for the bus interface. Each register is cleared independently by writing a one. A maskable interrupt for the local processor is raised from the translation-unit copy.

Top module: `pcix_cfg_out_err`

## Requirements
- R1: With Mode 2 off, `cfg_addr_o` is laid out as follows. Bits 31:24 are zero. Bits 23:16 carry the bus number, bits 15:11 the device number and bits 10:8 the function. Bits 7:2 carry register bits 7:2, and bits 1:0 are zero. Device numbers 8 to 31 are encoded this way without restriction.
- R2: With Mode 2 on, bits 31:28 of `cfg_addr_o` are zero and bits 27:24 carry register bits 11:8. The other fields are as in R1.
- R3: `cfg_blocked_o` is 1 only when Mode 2 is on and the device number is above 7. With Mode 2 off it is always 0.
- R4: One cycle after `bus_done_i` rises for a read, `ib_cpl_valid_o` is 1. `ib_cpl_abort_o` is 1 when `cmpl_code_i` is 1 (master abort), 2 (target abort) or 3 (uncorrectable data error). It is 0 when `cmpl_code_i` is 0 (normal).
- R5: One cycle after `bus_done_i` rises for a write, `ib_cpl_valid_o` is 1 and `ib_cpl_abort_o` is 0, whatever the value of `cmpl_code_i`.
- R6: A split completion message sets status bit 0 only when it has class 2 with index 1, or class 1 with index 2. Every other class and index pair leaves the status unchanged.
- R7: A read that ends with code 3 sets status bit 1. Codes 1 and 2 set no status bit.
- R8: While `parity_en_i` is 0, no status bit is set.
- R9: Each event sets the same bit in both `unit_stat_o` and `link_stat_o`. Writing a one to a bit of `unit_clr_i` or `link_clr_i` clears only that bit in that copy. A set and a clear of the same bit in the same cycle leave the bit at 1.
- R10: `irq_o` is the OR, over both bits, of `unit_stat_o` ANDed with `irq_mask_i`.
- R11: After reset, the completion outputs, both status copies and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode2_i | input | 1 | Bus is operating in Mode 2 |
| parity_en_i | input | 1 | Parity checking enabled |
| cfg_bus_i | input | 8 | Target bus number |
| cfg_dev_i | input | 5 | Target device number |
| cfg_fn_i | input | 3 | Target function number |
| cfg_reg_i | input | 12 | Register byte offset |
| cfg_addr_o | output | 32 | Formatted configuration address |
| cfg_blocked_o | output | 1 | Device cannot be reached in Mode 2 |
| bus_done_i | input | 1 | One-cycle pulse: bus transaction ended |
| bus_write_i | input | 1 | Ended transaction was a write |
| cmpl_code_i | input | 2 | Outcome: 0 normal, 1 master abort, 2 target abort, 3 data error |
| smsg_valid_i | input | 1 | One-cycle pulse: split completion error message received |
| smsg_class_i | input | 4 | Message class |
| smsg_index_i | input | 8 | Message index |
| ib_cpl_valid_o | output | 1 | Internal completion valid |
| ib_cpl_abort_o | output | 1 | Internal completion aborted |
| unit_stat_o | output | 2 | Translation-unit status: bit 0 split write error, bit 1 read data error |
| unit_clr_i | input | 2 | Write-one-to-clear for `unit_stat_o` |
| link_stat_o | output | 2 | Bus-interface status, same bit meanings |
| link_clr_i | input | 2 | Write-one-to-clear for `link_stat_o` |
| irq_mask_i | input | 2 | Interrupt enable for each status bit |
| irq_o | output | 1 | Interrupt to the local processor |

## Verification
The assertions assume the following about the inputs:
- `bus_done_i` and `smsg_valid_i` are single-cycle pulses.
- `bus_write_i` and `cmpl_code_i` are meaningful only in the cycle of a done pulse.
- The address fields are treated as static inputs, and the address is checked combinationally.

The bench changes every input on the falling edge and holds it for a full cycle. It raises each event pulse for exactly one cycle, and it applies a clear in the same cycle as an event only in the dedicated set-wins test.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   typedef enum logic [1:0] {
      CST_OK      = 2'd0,
      CST_MABORT  = 2'd1,
      CST_TABORT  = 2'd2,
      CST_DATAERR = 2'd3
   } cst_e;

   localparam int NUM_ERR  = 2;
   localparam int ERR_SCE  = 0;
   localparam int ERR_MDP  = 1;
   localparam int NUM_COPY = 2;

   localparam int MSG_CLS_COMPLETER = 2;
   localparam int MSG_IDX_SPLIT_WR  = 1;
   localparam int MSG_CLS_BRIDGE    = 1;
   localparam int MSG_IDX_WR_UNCOR  = 2;

endpackage

// File: rtl/cfgx_addr_fmt.sv
module cfgx_addr_fmt #(
   parameter int ADDR_W         = 32,
   parameter int BUS_W          = 8,
   parameter int DEV_W          = 5,
   parameter int FN_W           = 3,
   parameter int REG_W          = 12,
   parameter bit MODE2_SUPPORT  = 1'b1,
   parameter int MODE2_DEV_LAST = 7
) (
   input  logic              mode2_i,
   input  logic [BUS_W-1:0]  bus_i,
   input  logic [DEV_W-1:0]  dev_i,
   input  logic [FN_W-1:0]   fn_i,
   input  logic [REG_W-1:0]  creg_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              blocked_o
);
   localparam int DW_LSB  = 2;
   localparam int DW_W    = 6;
   localparam int FN_LSB  = DW_LSB + DW_W;
   localparam int DEV_LSB = FN_LSB + FN_W;
   localparam int BUS_LSB = DEV_LSB + DEV_W;
   localparam int EXT_LSB = BUS_LSB + BUS_W;
   localparam int EXT_W   = REG_W - (DW_LSB + DW_W);

   logic m2;

   generate
      if (MODE2_SUPPORT) begin : g_m2
         assign m2 = mode2_i;
      end else begin : g_conv
         logic unused_mode2;
         assign unused_mode2 = mode2_i;
         assign m2 = 1'b0;
      end
   endgenerate

   logic [DW_LSB-1:0] unused_reg_lo;
   assign unused_reg_lo = creg_i[DW_LSB-1:0];

   always_comb begin
      addr_o                           = '0;
      addr_o[DW_LSB  +: DW_W]          = creg_i[DW_LSB +: DW_W];
      addr_o[FN_LSB  +: FN_W]          = fn_i;
      addr_o[DEV_LSB +: DEV_W]         = dev_i;
      addr_o[BUS_LSB +: BUS_W]         = bus_i;
      if (m2) begin
         addr_o[EXT_LSB +: EXT_W]      = creg_i[REG_W-1 -: EXT_W];
      end
   end

   assign blocked_o = m2 && (dev_i > DEV_W'(MODE2_DEV_LAST));

endmodule

// File: rtl/cfgx_cmpl_map.sv
module cfgx_cmpl_map
   import cfgx_pkg::*;
#(
   parameter int MSG_CLS_W = 4,
   parameter int MSG_IDX_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 parity_en_i,
   input  logic                 done_i,
   input  logic                 write_i,
   input  cst_e                 code_i,
   input  logic                 smsg_valid_i,
   input  logic [MSG_CLS_W-1:0] smsg_class_i,
   input  logic [MSG_IDX_W-1:0] smsg_index_i,
   output logic                 cpl_valid_o,
   output logic                 cpl_abort_o,
   output logic [NUM_ERR-1:0]   err_evt_o
);
   logic msg_wr_uncor;
   logic cpl_valid_q, cpl_abort_q;

   assign msg_wr_uncor =
        ((smsg_class_i == MSG_CLS_W'(MSG_CLS_COMPLETER)) &&
         (smsg_index_i == MSG_IDX_W'(MSG_IDX_SPLIT_WR)))
     || ((smsg_class_i == MSG_CLS_W'(MSG_CLS_BRIDGE)) &&
         (smsg_index_i == MSG_IDX_W'(MSG_IDX_WR_UNCOR)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpl_valid_q <= 1'b0;
         cpl_abort_q <= 1'b0;
      end else begin
         cpl_valid_q <= done_i;
         cpl_abort_q <= done_i && !write_i && (code_i != CST_OK);
      end
   end

   always_comb begin
      err_evt_o          = '0;
      err_evt_o[ERR_SCE] = parity_en_i && smsg_valid_i && msg_wr_uncor;
      err_evt_o[ERR_MDP] = parity_en_i && done_i && !write_i
                           && (code_i == CST_DATAERR);
   end

   assign cpl_valid_o = cpl_valid_q;
   assign cpl_abort_o = cpl_abort_q;

endmodule

// File: rtl/cfgx_err_stat.sv
module cfgx_err_stat #(
   parameter int N_BIT  = 2,
   parameter int N_COPY = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [N_BIT-1:0]             evt_i,
   input  logic [N_COPY-1:0][N_BIT-1:0] clr_i,
   input  logic [N_BIT-1:0]             mask_i,
   output logic [N_COPY-1:0][N_BIT-1:0] stat_o,
   output logic                         irq_o
);
   generate
      for (genvar c = 0; c < N_COPY; c++) begin : g_copy
         logic [N_BIT-1:0] bits_q;
         for (genvar b = 0; b < N_BIT; b++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  bits_q[b] <= 1'b0;
               else if (evt_i[b])
                  bits_q[b] <= 1'b1;
               else if (clr_i[c][b])
                  bits_q[b] <= 1'b0;
            end
         end
         assign stat_o[c] = bits_q;
      end
   endgenerate

   assign irq_o = |(stat_o[0] & mask_i);

endmodule

// File: rtl/pcix_cfg_out_err.sv
module pcix_cfg_out_err
   import cfgx_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int BUS_W          = 8,
   parameter int DEV_W          = 5,
   parameter int FN_W           = 3,
   parameter int REG_W          = 12,
   parameter int MSG_CLS_W      = 4,
   parameter int MSG_IDX_W      = 8,
   parameter bit MODE2_SUPPORT  = 1'b1,
   parameter int MODE2_DEV_LAST = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode2_i,
   input  logic                 parity_en_i,
   input  logic [BUS_W-1:0]     cfg_bus_i,
   input  logic [DEV_W-1:0]     cfg_dev_i,
   input  logic [FN_W-1:0]      cfg_fn_i,
   input  logic [REG_W-1:0]     cfg_reg_i,
   output logic [ADDR_W-1:0]    cfg_addr_o,
   output logic                 cfg_blocked_o,
   input  logic                 bus_done_i,
   input  logic                 bus_write_i,
   input  logic [1:0]           cmpl_code_i,
   input  logic                 smsg_valid_i,
   input  logic [MSG_CLS_W-1:0] smsg_class_i,
   input  logic [MSG_IDX_W-1:0] smsg_index_i,
   output logic                 ib_cpl_valid_o,
   output logic                 ib_cpl_abort_o,
   output logic [NUM_ERR-1:0]   unit_stat_o,
   input  logic [NUM_ERR-1:0]   unit_clr_i,
   output logic [NUM_ERR-1:0]   link_stat_o,
   input  logic [NUM_ERR-1:0]   link_clr_i,
   input  logic [NUM_ERR-1:0]   irq_mask_i,
   output logic                 irq_o
);
   localparam int FIELD_TOP = 8 + FN_W + DEV_W + BUS_W;
   localparam int EXT_W     = REG_W - 8;

   generate
      if (REG_W < 9) begin : g_bad_reg
         $error("REG_W must leave extended register bits above bit 7");
      end
      if (FIELD_TOP + EXT_W > ADDR_W) begin : g_bad_addr
         $error("address fields do not fit into ADDR_W");
      end
      if (MODE2_DEV_LAST >= (1 << DEV_W)) begin : g_bad_dev
         $error("MODE2_DEV_LAST exceeds the device field");
      end
   endgenerate

   logic [NUM_ERR-1:0]                err_evt;
   logic [NUM_COPY-1:0][NUM_ERR-1:0]  stat_all;
   logic [NUM_COPY-1:0][NUM_ERR-1:0]  clr_all;
   cst_e                              code;

   assign code    = cst_e'(cmpl_code_i);
   assign clr_all = {link_clr_i, unit_clr_i};

   cfgx_addr_fmt #(
      .ADDR_W        (ADDR_W),
      .BUS_W         (BUS_W),
      .DEV_W         (DEV_W),
      .FN_W          (FN_W),
      .REG_W         (REG_W),
      .MODE2_SUPPORT (MODE2_SUPPORT),
      .MODE2_DEV_LAST(MODE2_DEV_LAST)
   ) i_addr_fmt (
      .mode2_i   (mode2_i),
      .bus_i     (cfg_bus_i),
      .dev_i     (cfg_dev_i),
      .fn_i      (cfg_fn_i),
      .creg_i    (cfg_reg_i),
      .addr_o    (cfg_addr_o),
      .blocked_o (cfg_blocked_o)
   );

   cfgx_cmpl_map #(
      .MSG_CLS_W (MSG_CLS_W),
      .MSG_IDX_W (MSG_IDX_W)
   ) i_cmpl_map (
      .clk          (clk),
      .rst_n        (rst_n),
      .parity_en_i  (parity_en_i),
      .done_i       (bus_done_i),
      .write_i      (bus_write_i),
      .code_i       (code),
      .smsg_valid_i (smsg_valid_i),
      .smsg_class_i (smsg_class_i),
      .smsg_index_i (smsg_index_i),
      .cpl_valid_o  (ib_cpl_valid_o),
      .cpl_abort_o  (ib_cpl_abort_o),
      .err_evt_o    (err_evt)
   );

   cfgx_err_stat #(
      .N_BIT  (NUM_ERR),
      .N_COPY (NUM_COPY)
   ) i_err_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (err_evt),
      .clr_i  (clr_all),
      .mask_i (irq_mask_i),
      .stat_o (stat_all),
      .irq_o  (irq_o)
   );

   assign unit_stat_o = stat_all[0];
   assign link_stat_o = stat_all[1];

endmodule

// File: rtl/cfgx_err_chk.sv
module cfgx_err_chk #(
   parameter int ADDR_W         = 32,
   parameter int DEV_W          = 5,
   parameter int MSG_CLS_W      = 4,
   parameter int MSG_IDX_W      = 8,
   parameter bit MODE2_SUPPORT  = 1'b1,
   parameter int MODE2_DEV_LAST = 7
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 mode2_i,
   input logic                 parity_en_i,
   input logic [DEV_W-1:0]     cfg_dev_i,
   input logic [ADDR_W-1:0]    cfg_addr_o,
   input logic                 cfg_blocked_o,
   input logic                 bus_done_i,
   input logic                 bus_write_i,
   input logic [1:0]           cmpl_code_i,
   input logic                 smsg_valid_i,
   input logic [MSG_CLS_W-1:0] smsg_class_i,
   input logic [MSG_IDX_W-1:0] smsg_index_i,
   input logic                 ib_cpl_valid_o,
   input logic                 ib_cpl_abort_o,
   input logic [1:0]           unit_stat_o,
   input logic [1:0]           link_stat_o,
   input logic [1:0]           irq_mask_i,
   input logic                 irq_o
);
   logic m2_on;
   assign m2_on = MODE2_SUPPORT && mode2_i;

   AST_MODE2_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      m2_on |-> (cfg_addr_o[ADDR_W-1:28] == '0)); // R2

   AST_CONV_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !m2_on |-> (cfg_addr_o[ADDR_W-1:24] == '0)); // R1

   AST_MODE2_DEV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (m2_on && (cfg_dev_i > DEV_W'(MODE2_DEV_LAST))) |-> cfg_blocked_o); // R3

   AST_CONV_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !m2_on |-> !cfg_blocked_o); // R3

   AST_RD_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_done_i && !bus_write_i && (cmpl_code_i != 2'd0))
      |=> (ib_cpl_valid_o && ib_cpl_abort_o)); // R4

   AST_WR_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_done_i && bus_write_i) |=> (ib_cpl_valid_o && !ib_cpl_abort_o)); // R5

   AST_SPLIT_WR_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (parity_en_i && smsg_valid_i &&
       (((smsg_class_i == 4'h2) && (smsg_index_i == 8'h01)) ||
        ((smsg_class_i == 4'h1) && (smsg_index_i == 8'h02))))
      |=> (unit_stat_o[0] && link_stat_o[0])); // R6

   AST_NO_SET_WITHOUT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      !parity_en_i |=> ((unit_stat_o & ~$past(unit_stat_o)) == 2'b00)); // R8

   AST_IRQ_NEEDS_ENABLED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((unit_stat_o & irq_mask_i) != 2'b00)); // R10

   AST_IRQ_FROM_ENABLED_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      ((unit_stat_o & irq_mask_i) != 2'b00) |-> irq_o); // R10

endmodule

bind pcix_cfg_out_err cfgx_err_chk #(
   .ADDR_W         (ADDR_W),
   .DEV_W          (DEV_W),
   .MSG_CLS_W      (MSG_CLS_W),
   .MSG_IDX_W      (MSG_IDX_W),
   .MODE2_SUPPORT  (MODE2_SUPPORT),
   .MODE2_DEV_LAST (MODE2_DEV_LAST)
) i_err_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode2_i        (mode2_i),
   .parity_en_i    (parity_en_i),
   .cfg_dev_i      (cfg_dev_i),
   .cfg_addr_o     (cfg_addr_o),
   .cfg_blocked_o  (cfg_blocked_o),
   .bus_done_i     (bus_done_i),
   .bus_write_i    (bus_write_i),
   .cmpl_code_i    (cmpl_code_i),
   .smsg_valid_i   (smsg_valid_i),
   .smsg_class_i   (smsg_class_i),
   .smsg_index_i   (smsg_index_i),
   .ib_cpl_valid_o (ib_cpl_valid_o),
   .ib_cpl_abort_o (ib_cpl_abort_o),
   .unit_stat_o    (unit_stat_o),
   .link_stat_o    (link_stat_o),
   .irq_mask_i     (irq_mask_i),
   .irq_o          (irq_o)
);

// File: tb/test_pcix_cfg_out_err.sv
`timescale 1ns/1ps
module test_pcix_cfg_out_err;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode2 = 1'b0, parity_en = 1'b0;
   logic [7:0]  bus = '0;
   logic [4:0]  dev = '0;
   logic [2:0]  fn = '0;
   logic [11:0] creg = '0;
   logic [31:0] addr;
   logic        blocked;
   logic        done = 1'b0, wr = 1'b0;
   logic [1:0]  code = '0;
   logic        smsg_v = 1'b0;
   logic [3:0]  smsg_c = '0;
   logic [7:0]  smsg_i = '0;
   logic        cpl_v, cpl_a;
   logic [1:0]  ustat, lstat;
   logic [1:0]  uclr = '0, lclr = '0, mask = '0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   pcix_cfg_out_err i_pcix_cfg_out_err (
      .clk(clk), .rst_n(rst_n), .mode2_i(mode2), .parity_en_i(parity_en),
      .cfg_bus_i(bus), .cfg_dev_i(dev), .cfg_fn_i(fn), .cfg_reg_i(creg),
      .cfg_addr_o(addr), .cfg_blocked_o(blocked),
      .bus_done_i(done), .bus_write_i(wr), .cmpl_code_i(code),
      .smsg_valid_i(smsg_v), .smsg_class_i(smsg_c), .smsg_index_i(smsg_i),
      .ib_cpl_valid_o(cpl_v), .ib_cpl_abort_o(cpl_a),
      .unit_stat_o(ustat), .unit_clr_i(uclr),
      .link_stat_o(lstat), .link_clr_i(lclr),
      .irq_mask_i(mask), .irq_o(irq)
   );

   // mode2, bus, dev, fn, reg, expected address, expected blocked
   localparam int NVEC = 7;
   localparam logic [61:0] VEC [NVEC] = '{
      {1'b0, 8'h12, 5'd3,  3'd1, 12'h0A4, 32'h001219A4, 1'b0}, // R1
      {1'b1, 8'h12, 5'd3,  3'd1, 12'hFA4, 32'h0F1219A4, 1'b0}, // R2
      {1'b0, 8'h01, 5'd12, 3'd0, 12'h3FF, 32'h000160FC, 1'b0}, // R1 R3
      {1'b1, 8'h01, 5'd12, 3'd0, 12'h3FF, 32'h030160FC, 1'b1}, // R2 R3
      {1'b1, 8'hFF, 5'd7,  3'd7, 12'h800, 32'h08FF3F00, 1'b0}, // R2 R3
      {1'b1, 8'h00, 5'd8,  3'd0, 12'h000, 32'h00004000, 1'b1}, // R3
      {1'b1, 8'h00, 5'd31, 3'd0, 12'h100, 32'h0100F800, 1'b1}  // R3
   };

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_end(input logic w, input logic [1:0] c);
      @(negedge clk);
      done = 1'b1; wr = w; code = c;
      @(negedge clk);
      done = 1'b0; wr = 1'b0; code = 2'd0;
   endtask

   task automatic split_msg(input logic [3:0] c, input logic [7:0] i);
      @(negedge clk);
      smsg_v = 1'b1; smsg_c = c; smsg_i = i;
      @(negedge clk);
      smsg_v = 1'b0; smsg_c = '0; smsg_i = '0;
   endtask

   task automatic clear(input logic [1:0] u, input logic [1:0] l);
      @(negedge clk);
      uclr = u; lclr = l;
      @(negedge clk);
      uclr = '0; lclr = '0;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 cpl_valid", {31'd0, cpl_v}, 32'd0);
      check("R11 cpl_abort", {31'd0, cpl_a}, 32'd0);
      check("R11 stat", {28'd0, ustat, lstat}, 32'd0);
      check("R11 irq", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;

      for (int k = 0; k < NVEC; k++) begin
         @(negedge clk);
         {mode2, bus, dev, fn, creg} = VEC[k][61:33];
         #1;
         check($sformatf("R1/R2 addr vec%0d", k), addr, VEC[k][32:1]);
         check($sformatf("R3 blocked vec%0d", k), {31'd0, blocked}, {31'd0, VEC[k][0]});
      end
      mode2 = 1'b0;

      parity_en = 1'b1;
      bus_end(1'b0, 2'd0);
      check("R4 read ok valid", {31'd0, cpl_v}, 32'd1);
      check("R4 read ok abort", {31'd0, cpl_a}, 32'd0);
      bus_end(1'b0, 2'd1);
      check("R4 read master abort", {30'd0, cpl_v, cpl_a}, 32'd3);
      check("R7 master abort no status", {30'd0, ustat}, 32'd0);
      bus_end(1'b0, 2'd2);
      check("R4 read target abort", {30'd0, cpl_v, cpl_a}, 32'd3);
      check("R7 target abort no status", {30'd0, ustat}, 32'd0);
      bus_end(1'b0, 2'd3);
      check("R4 read data error", {30'd0, cpl_v, cpl_a}, 32'd3);
      check("R7 unit bit1", {30'd0, ustat}, 32'd2);
      check("R9 link bit1", {30'd0, lstat}, 32'd2);
      check("R10 masked irq", {31'd0, irq}, 32'd0);
      mask = 2'b10; #1;
      check("R10 enabled irq", {31'd0, irq}, 32'd1);
      @(negedge clk);
      check("R5 idle valid drops", {31'd0, cpl_v}, 32'd0);

      bus_end(1'b1, 2'd1);
      check("R5 write valid no abort", {30'd0, cpl_v, cpl_a}, 32'd2);
      bus_end(1'b1, 2'd3);
      check("R5 write data code no abort", {30'd0, cpl_v, cpl_a}, 32'd2);

      clear(2'b10, 2'b00);
      check("R9 unit cleared", {30'd0, ustat}, 32'd0);
      check("R9 link kept", {30'd0, lstat}, 32'd2);
      check("R10 irq after clear", {31'd0, irq}, 32'd0);
      clear(2'b00, 2'b10);
      check("R9 link cleared", {30'd0, lstat}, 32'd0);

      split_msg(4'h2, 8'h01);
      check("R6 class2 idx1 unit", {30'd0, ustat}, 32'd1);
      check("R6 class2 idx1 link", {30'd0, lstat}, 32'd1);
      clear(2'b11, 2'b11);
      split_msg(4'h1, 8'h02);
      check("R6 class1 idx2", {28'd0, ustat, lstat}, 32'h5);
      clear(2'b11, 2'b11);
      split_msg(4'h2, 8'h02);
      split_msg(4'h1, 8'h01);
      split_msg(4'h3, 8'h01);
      split_msg(4'h2, 8'h11);
      check("R6 other pairs ignored", {28'd0, ustat, lstat}, 32'h0);

      parity_en = 1'b0;
      split_msg(4'h2, 8'h01);
      bus_end(1'b0, 2'd3);
      check("R4 abort without parity", {30'd0, cpl_v, cpl_a}, 32'd3);
      check("R8 no status without parity", {28'd0, ustat, lstat}, 32'h0);

      parity_en = 1'b1;
      @(negedge clk);
      smsg_v = 1'b1; smsg_c = 4'h1; smsg_i = 8'h02; uclr = 2'b01;
      @(negedge clk);
      smsg_v = 1'b0; smsg_c = '0; smsg_i = '0; uclr = '0;
      check("R9 set wins over clear", {30'd0, ustat}, 32'd1);
      mask = 2'b01; #1;
      check("R10 irq bit0", {31'd0, irq}, 32'd1);
      mask = 2'b00; #1;
      check("R10 irq masked", {31'd0, irq}, 32'd0);

      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule